// File: doc/BRIEF.md
# PS/2 Serial Frame Receiver

This block takes the two open-drain wires of a PS/2 keyboard or mouse link and turns each 11-bit device-to-host frame into a byte. The block synchronises and de-glitches both wires. It samples the data wire on every falling edge of the device clock and checks the frame shape and its parity. It then presents the result for one system-clock cycle on a valid strobe. Two flags travel with the byte: one for a parity failure and one for a stalled frame.

A host-side output buffer and its interrupt logic are meant to sit after this block and consume each strobe. The host may forbid the device from sending. While its inhibit input is high, the receiver pulls the clock wire low through an open-drain enable, throws away any frame in progress and accepts nothing.

Top module: `ps2_rx_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `rx_valid_o` and `clk_drive_low_o` are 0.
- R2: A frame is sampled on falling edges of the filtered clock wire in this order: a start bit of 0, eight data bits least significant first, a parity bit, and a stop bit of 1. After the stop bit, `rx_valid_o` pulses for exactly one cycle with the data byte on `rx_byte_o` and `rx_timeout_o` = 0.
- R3: The data bits and the parity bit together must hold an odd number of ones. If they do, `rx_parity_err_o` is 0 with the strobe. If the count is even, `rx_parity_err_o` is 1 and the byte is still delivered.
- R4: A falling edge that finds the data wire at 1 while the receiver is idle is not a start bit. It produces no strobe, and the receiver keeps waiting for a start bit of 0.
- R5: A frame whose stop bit samples as 0 is discarded with no strobe, and the receiver returns to waiting for a start bit.
- R6: Once a start bit is accepted, the frame times out if the filtered clock wire makes no transition for `TIMEOUT_CYC` consecutive system cycles. The timeout gives one strobe with `rx_timeout_o` = 1, `rx_byte_o` = 0x00 and `rx_parity_err_o` = 0, and the receiver returns to idle. No strobe appears earlier than that.
- R7: `clk_drive_low_o` equals the value `inhibit_i` had one cycle earlier.
- R8: While `inhibit_i` is high, no strobe is produced and any partial frame is dropped. The next frame after release is decoded from its own start bit.
- R9: A pulse on the clock wire that lasts fewer than `FILT_LEN` system cycles does not count as a clock edge, so it neither shifts a bit nor restarts a frame.
- R10: Every strobe is a single cycle, and each complete well-formed frame gives exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Level of the open-drain clock wire |
| ps2_dat_in | input | 1 | Level of the open-drain data wire |
| inhibit_i | input | 1 | Host forbids device transmission |
| clk_drive_low_o | output | 1 | Open-drain enable: 1 pulls the clock wire low |
| rx_valid_o | output | 1 | One-cycle strobe for a finished or timed-out frame |
| rx_byte_o | output | 8 | Received byte, 0x00 on timeout |
| rx_parity_err_o | output | 1 | Even parity seen, qualified by the strobe |
| rx_timeout_o | output | 1 | Frame stalled, qualified by the strobe |

## Verification
The assertions assume that `inhibit_i` is synchronous to the system clock and that the outputs only carry meaning in the cycle of the strobe. The stimulus model drives the wires the way a device does. Each half bit period is much longer than the synchroniser and filter delay together, and the data wire changes only while the clock wire is high, so each falling edge samples settled data. The stimulus applies inhibit through the wired-AND of the clock wire. Deliberate clock-wire glitches are kept shorter than the filter window, and the stalled frame is left idle for longer than `TIMEOUT_CYC`.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } rx_phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              timed_out;
    } rx_word_t;

    // returns 1 when data plus parity hold an even number of ones
    function automatic logic parity_is_even(input logic [DATA_W-1:0] d, input logic p);
        return ~(^{d, p});
    endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q) begin
                level_q <= 1'b1;
            end else if (~|hist_q) begin
                level_q <= 1'b0;
            end
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/ps2_stall_timer.sv
module ps2_stall_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic kick_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = run_i && !kick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || kick_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2_frame_fsm.sv
module ps2_frame_fsm
    import ps2_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_lvl_i,
    input  logic     dat_lvl_i,
    input  logic     inhibit_i,
    input  logic     expire_i,
    output logic     active_o,
    output logic     toggle_o,
    output logic     valid_o,
    output rx_word_t word_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_phase_e         phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              clk_prev_q;
    logic              valid_q;
    rx_word_t          word_q;
    logic              fall;

    assign fall     = clk_prev_q & ~clk_lvl_i;
    assign toggle_o = clk_prev_q ^ clk_lvl_i;
    assign active_o = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev_q <= 1'b1;
            phase_q    <= PH_IDLE;
            idx_q      <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            valid_q    <= 1'b0;
            word_q     <= '0;
        end else begin
            clk_prev_q <= clk_lvl_i;
            valid_q    <= 1'b0;
            if (inhibit_i) begin
                phase_q <= PH_IDLE;
                idx_q   <= '0;
            end else if (fall) begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (!dat_lvl_i) begin
                            phase_q <= PH_DATA;
                            idx_q   <= '0;
                        end
                    end
                    PH_DATA: begin
                        shreg_q <= {dat_lvl_i, shreg_q[DATA_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                        if (idx_q == IDX_LAST) begin
                            phase_q <= PH_PARITY;
                        end
                    end
                    PH_PARITY: begin
                        par_q   <= dat_lvl_i;
                        phase_q <= PH_STOP;
                    end
                    PH_STOP: begin
                        phase_q <= PH_IDLE;
                        if (dat_lvl_i) begin
                            valid_q <= 1'b1;
                            word_q  <= '{data: shreg_q,
                                         par_err: parity_is_even(shreg_q, par_q),
                                         timed_out: 1'b0};
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end else if (expire_i) begin
                phase_q <= PH_IDLE;
                valid_q <= 1'b1;
                word_q  <= '{data: '0, par_err: 1'b0, timed_out: 1'b1};
            end
        end
    end

    assign valid_o = valid_q;
    assign word_o  = word_q;
endmodule

// File: rtl/ps2_rx_top.sv
module ps2_rx_top
    import ps2_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ps2_clk_in,
    input  logic              ps2_dat_in,
    input  logic              inhibit_i,
    output logic              clk_drive_low_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_parity_err_o,
    output logic              rx_timeout_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               active;
    logic               toggle;
    logic               expire;
    logic               valid;
    rx_word_t           word;
    logic               drive_q;

    assign raw_lines = {ps2_dat_in, ps2_clk_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        ps2_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_lines[g]),
            .level_o(filt_lines[g])
        );
    end

    ps2_stall_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run_i   (active),
        .kick_i  (toggle),
        .expire_o(expire)
    );

    ps2_frame_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .clk_lvl_i(filt_lines[0]),
        .dat_lvl_i(filt_lines[1]),
        .inhibit_i(inhibit_i),
        .expire_i (expire),
        .active_o (active),
        .toggle_o (toggle),
        .valid_o  (valid),
        .word_o   (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= inhibit_i;
        end
    end

    assign clk_drive_low_o = drive_q;
    assign rx_valid_o      = valid;
    assign rx_byte_o       = word.data;
    assign rx_parity_err_o = word.par_err;
    assign rx_timeout_o    = word.timed_out;
endmodule

// File: rtl/ps2_rx_chk.sv
module ps2_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       inhibit_i,
    input logic       clk_drive_low_o,
    input logic       rx_valid_o,
    input logic [7:0] rx_byte_o,
    input logic       rx_parity_err_o,
    input logic       rx_timeout_o
);
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    p_drive_follow_r7: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> clk_drive_low_o);

    p_drive_release_r7: assert property (@(posedge clk) disable iff (rst)
        !inhibit_i |=> !clk_drive_low_o);

    p_quiet_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> !rx_valid_o);

    p_timeout_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && rx_timeout_o) |-> (rx_byte_o == 8'h00 && !rx_parity_err_o));
endmodule

bind ps2_rx_top ps2_rx_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .inhibit_i      (inhibit_i),
    .clk_drive_low_o(clk_drive_low_o),
    .rx_valid_o     (rx_valid_o),
    .rx_byte_o      (rx_byte_o),
    .rx_parity_err_o(rx_parity_err_o),
    .rx_timeout_o   (rx_timeout_o)
);

// File: tb/ps2_rx_top_tb_top.sv
module ps2_rx_top_tb_top;
    localparam int TMO  = 2000;
    localparam int HALF = 40;
    localparam int GAP  = 200;

    typedef struct packed {
        logic [7:0] b;
        logic       pe;
        logic       to;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_clk = 1'b1;
    logic       dev_dat = 1'b1;
    logic       inhibit = 1'b0;
    logic       drive_low;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       rx_pe;
    logic       rx_to;
    logic       line_clk;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    int frames_ok = 0;
    bit finished = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    assign line_clk = dev_clk & ~drive_low;

    always #10 clk = ~clk;

    ps2_rx_top #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .ps2_clk_in     (line_clk),
        .ps2_dat_in     (dev_dat),
        .inhibit_i      (inhibit),
        .clk_drive_low_o(drive_low),
        .rx_valid_o     (rx_valid),
        .rx_byte_o      (rx_byte),
        .rx_parity_err_o(rx_pe),
        .rx_timeout_o   (rx_to)
    );

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            strobes++;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected strobe actual=%h/%b/%b expected=none",
                         rx_byte, rx_pe, rx_to);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rx_byte !== e.b || rx_pe !== e.pe || rx_to !== e.to) begin
                    bad++;
                    $display("FAIL %s byte/perr/tmo actual=%h/%b/%b expected=%h/%b/%b",
                             t, rx_byte, rx_pe, rx_to, e.b, e.pe, e.to);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        dev_dat = b;
        if (glitch) begin
            wait_cyc(15);
            dev_clk = 1'b0;
            wait_cyc(2);
            dev_clk = 1'b1;
            wait_cyc(HALF - 17);
        end else begin
            wait_cyc(HALF);
        end
        dev_clk = 1'b0;
        wait_cyc(HALF);
        dev_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input logic stop_b,
                              input bit glitch, input bit expect_it, input string tag);
        logic par;
        par = ~(^b);
        if (bad_par) par = ~par;
        if (expect_it) begin
            exp_q.push_back('{b: b, pe: bad_par, to: 1'b0});
            tag_q.push_back(tag);
            frames_ok++;
        end
        put_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) put_bit(b[i], glitch && (i == 3));
        put_bit(par, 1'b0);
        put_bit(stop_b, 1'b0);
        dev_dat = 1'b1;
        wait_cyc(GAP);
    endtask

    task automatic drained(input string tag);
        check(tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0;
        wait_cyc(5);
        check("R1 valid in reset", rx_valid, 0);
        check("R1 drive in reset", drive_low, 0);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 valid after reset", rx_valid, 0);
        check("R1 drive after reset", drive_low, 0);
        wait_cyc(20);

        // R2: plain frames, several bit patterns
        send_frame(8'hA5, 0, 1'b1, 0, 1, "R2 A5");
        send_frame(8'h00, 0, 1'b1, 0, 1, "R2 00");
        send_frame(8'hFF, 0, 1'b1, 0, 1, "R2 FF");
        send_frame(8'h3C, 0, 1'b1, 0, 1, "R2 3C");
        send_frame(8'h81, 0, 1'b1, 0, 1, "R2 81");
        drained("R2 drained");

        // R3: even parity flagged, byte kept
        send_frame(8'h5A, 1, 1'b1, 0, 1, "R3 5A even");
        send_frame(8'h01, 1, 1'b1, 0, 1, "R3 01 even");
        send_frame(8'h01, 0, 1'b1, 0, 1, "R3 01 odd");
        drained("R3 drained");

        // R4: falling edge with data high is not a start
        s0 = strobes;
        put_bit(1'b1, 1'b0);
        wait_cyc(GAP);
        check("R4 no strobe on high start", strobes, s0);
        send_frame(8'h69, 0, 1'b1, 0, 1, "R4 resync 69");
        drained("R4 drained");

        // R5: stop bit 0 drops the frame
        s0 = strobes;
        send_frame(8'h77, 0, 1'b0, 0, 0, "R5");
        check("R5 no strobe on bad stop", strobes, s0);
        send_frame(8'h12, 0, 1'b1, 0, 1, "R5 next 12");
        drained("R5 drained");

        // R6: stalled frame times out
        s0 = strobes;
        exp_q.push_back('{b: 8'h00, pe: 1'b0, to: 1'b1});
        tag_q.push_back("R6 timeout");
        put_bit(1'b0, 1'b0);
        put_bit(1'b1, 1'b0);
        put_bit(1'b0, 1'b0);
        put_bit(1'b1, 1'b0);
        wait_cyc(TMO - 200);
        check("R6 not early", strobes, s0);
        wait_cyc(500);
        check("R6 one timeout strobe", strobes, s0 + 1);
        drained("R6 drained");
        send_frame(8'hC3, 0, 1'b1, 0, 1, "R6 after C3");

        // R7 / R8: inhibit mid-frame
        s0 = strobes;
        put_bit(1'b0, 1'b0);
        put_bit(1'b1, 1'b0);
        put_bit(1'b1, 1'b0);
        inhibit = 1'b1;
        wait_cyc(3);
        check("R7 drive low while inhibited", drive_low, 1);
        for (int i = 0; i < 6; i++) put_bit(1'b0, 1'b0);
        dev_dat = 1'b1;
        wait_cyc(50);
        check("R8 no strobe while inhibited", strobes, s0);
        inhibit = 1'b0;
        wait_cyc(3);
        check("R7 drive released", drive_low, 0);
        wait_cyc(50);
        send_frame(8'hE7, 0, 1'b1, 0, 1, "R8 fresh E7");
        send_frame(8'h4B, 0, 1'b1, 0, 1, "R8 fresh 4B");
        drained("R8 drained");

        // R9: short clock glitch ignored
        send_frame(8'h96, 0, 1'b1, 1, 1, "R9 glitch 96");
        send_frame(8'h0F, 1, 1'b1, 1, 1, "R9 glitch 0F");
        drained("R9 drained");

        // R10: one strobe per good frame (+1 timeout)
        check("R10 strobe count", strobes, frames_ok + 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule